// File: doc/BRIEF.md
# Matrix Tile Shape Configuration Unit

This unit keeps the shape settings for a bank of matrix tile registers: for every tile, how many rows it has and how many bytes each row holds. Software assembles a 64-byte configuration image in a staging buffer through a write port that is one or more bytes wide. A separate commit strobe then checks the image and, if the image is legal, copies it into the active configuration. The active row counts and row widths go straight to the tile storage.

A palette number of zero in a committed image, or a release strobe, returns the unit to its init state. All shapes become zero, the configured flag drops, and a one-cycle clear pulse tells the tile storage to zero its data. An illegal image raises a one-cycle fault pulse and leaves the active state exactly as it was. The active configuration can be read back through a combinational word port. While nothing is configured it reads as zeroes.

Top module: `tile_cfg_unit`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` into staging word `wr_addr_i` at the clock edge, with byte k of the word taken from bits [8k+7:8k]. The staging image has no effect on any output until it is committed.
- R2: Image layout: byte 0 is the palette number. Bytes 16+2t and 17+2t are the row width in bytes of tile t, low byte first. Byte 48+t is the row count of tile t. Every other byte is reserved.
- R3: A commit of an image with palette 1 that passes every check sets `configured_o` from the next cycle. From that cycle each tile's row count and row width appear on `tile_rows_o[8t+:8]` and `tile_bpr_o[16t+:16]`.
- R4: A commit with palette 1 is illegal when any of these holds: a row count is above 16, a row width is above 64, a row width is not a multiple of 4, or a reserved byte is nonzero. A commit with a palette above 1 is also illegal. For an illegal commit, `fault_o` is high for exactly the next cycle and the active state does not change.
- R5: A commit with palette 0 enters the init state, whatever the other bytes hold, and never faults. From the next cycle `configured_o` is low and all tile outputs are zero. `tile_clear_o` is high for that one cycle.
- R6: A `release_i` strobe enters the init state in the same way and pulses `tile_clear_o` for one cycle.
- R7: `rd_data_o` is staging-independent and combinational. It returns word `rd_addr_i` of the active image in the R2 layout, with byte 0 reading 1 when configured. It reads all zero while unconfigured.
- R8: When release and commit arrive in the same cycle, the release takes effect. The commit is dropped and raises no fault.
- R9: During and after reset, `configured_o`, `fault_o` and `tile_clear_o` are low and all tile outputs are zero. The staging image resets to all zero bytes, so a commit with no prior writes is an init-state commit.
- R10: A commit checks the staging image as it stood before that clock edge. A write in the same cycle lands in staging for later commits only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Staging write strobe |
| wr_addr_i | input | 4 | Staging word index |
| wr_data_i | input | 32 | Staging write data |
| commit_i | input | 1 | Check and apply the staging image |
| release_i | input | 1 | Return to init state |
| rd_addr_i | input | 4 | Readback word index |
| rd_data_o | output | 32 | Readback word of the active image |
| configured_o | output | 1 | Valid nonzero palette is active |
| fault_o | output | 1 | One-cycle pulse on an illegal commit |
| tile_clear_o | output | 1 | One-cycle pulse telling tile storage to zero its data |
| tile_rows_o | output | 64 | Row count per tile, 8 bits each |
| tile_bpr_o | output | 128 | Row width in bytes per tile, 16 bits each |

## Verification
Two pairs of actions can fall in the same clock. A release can coincide with a commit, and a staging write can coincide with a commit. The bench provokes both. It raises release and commit together on an image that would otherwise fault, and expects the init state with a clear pulse and no fault. It also rewrites the palette word in the very cycle it commits a different legal image, and expects that image to be applied while the rewrite only affects the following commit. A behavioural model of staging and active state predicts every output on every clock.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
  // Image geometry and field placement; neighbours decode these offsets.
  localparam int IMG_BYTES = 64;
  localparam int PAL_OFS   = 0;
  localparam int BPR_OFS   = 16;
  localparam int ROWS_OFS  = 48;
  localparam int ROW_W     = 8;
  localparam int BPR_W     = 16;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_INIT = 2'd1,
    ACT_LOAD = 2'd2,
    ACT_FLT  = 2'd3
  } cfg_act_e;

  function automatic bit is_field_byte(int b, int ntiles);
    return (b == PAL_OFS) ||
           (b >= BPR_OFS  && b < BPR_OFS + 2 * ntiles) ||
           (b >= ROWS_OFS && b < ROWS_OFS + ntiles);
  endfunction
endpackage

// File: rtl/tcfg_stage.sv
module tcfg_stage
  import tcfg_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int WORD_BITS = WORD_BYTES * 8,
  localparam int WORDS     = IMG_BYTES / WORD_BYTES,
  localparam int AW        = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [WORD_BITS-1:0]   wr_data,
  output logic [IMG_BYTES*8-1:0] image
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic                 word_en;
    logic [WORD_BITS-1:0] word_q;

    assign word_en = wr_en && (wr_addr == AW'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= wr_data;
      end
    end

    assign image[w*WORD_BITS +: WORD_BITS] = word_q;
  end
endmodule

// File: rtl/tcfg_validate.sv
module tcfg_validate
  import tcfg_pkg::*;
#(
  parameter int NTILES    = 8,
  parameter int MAX_ROWS  = 16,
  parameter int MAX_BPR   = 64,
  parameter int BPR_ALIGN = 4
) (
  input  logic [IMG_BYTES*8-1:0] image,
  output logic                   is_init,
  output logic                   is_legal
);
  localparam logic [ROW_W-1:0] ROWS_LIM  = ROW_W'(MAX_ROWS);
  localparam logic [BPR_W-1:0] BPR_LIM   = BPR_W'(MAX_BPR);
  localparam logic [BPR_W-1:0] BPR_MULT  = BPR_W'(BPR_ALIGN);

  logic [7:0]           palette;
  logic [NTILES-1:0]    tile_bad;
  logic [IMG_BYTES-1:0] rsv_bad;

  assign palette = image[PAL_OFS*8 +: 8];

  for (genvar t = 0; t < NTILES; t++) begin : g_tile
    logic [ROW_W-1:0] rows;
    logic [BPR_W-1:0] bpr;
    assign rows = image[(ROWS_OFS + t)*8 +: ROW_W];
    assign bpr  = image[(BPR_OFS + 2*t)*8 +: BPR_W];
    assign tile_bad[t] = (rows > ROWS_LIM) || (bpr > BPR_LIM) ||
                         ((bpr % BPR_MULT) != '0);
  end

  for (genvar b = 0; b < IMG_BYTES; b++) begin : g_rsv
    if (is_field_byte(b, NTILES)) begin : g_fld
      assign rsv_bad[b] = 1'b0;
    end else begin : g_res
      assign rsv_bad[b] = |image[b*8 +: 8];
    end
  end

  assign is_init  = (palette == 8'd0);
  assign is_legal = (palette == 8'd1) && !(|tile_bad) && !(|rsv_bad);
endmodule

// File: rtl/tcfg_state.sv
module tcfg_state
  import tcfg_pkg::*;
#(
  parameter int NTILES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic                    release_req,
  input  logic                    img_init,
  input  logic                    img_legal,
  input  logic [IMG_BYTES*8-1:0]  image,
  output logic                    cfg_q,
  output logic                    fault_q,
  output logic                    clear_q,
  output logic [NTILES*ROW_W-1:0] rows_q,
  output logic [NTILES*BPR_W-1:0] bpr_q,
  output logic [IMG_BYTES*8-1:0]  rb_image
);
  cfg_act_e                  act;
  logic                      shape_en;
  logic                      cfg_d;
  logic [NTILES*ROW_W-1:0]   rows_d;
  logic [NTILES*BPR_W-1:0]   bpr_d;
  logic [NTILES*ROW_W-1:0]   rows_img;
  logic [NTILES*BPR_W-1:0]   bpr_img;

  for (genvar t = 0; t < NTILES; t++) begin : g_pick
    assign rows_img[t*ROW_W +: ROW_W] = image[(ROWS_OFS + t)*8 +: ROW_W];
    assign bpr_img[t*BPR_W +: BPR_W]  = image[(BPR_OFS + 2*t)*8 +: BPR_W];
  end

  // Release outranks commit; commit decides init, load or fault.
  always_comb begin
    act = ACT_HOLD;
    if (release_req) begin
      act = ACT_INIT;
    end else if (commit) begin
      if (img_init)       act = ACT_INIT;
      else if (img_legal) act = ACT_LOAD;
      else                act = ACT_FLT;
    end
  end

  always_comb begin
    shape_en = (act == ACT_INIT) || (act == ACT_LOAD);
    cfg_d    = 1'b0;
    rows_d   = '0;
    bpr_d    = '0;
    if (act == ACT_LOAD) begin
      cfg_d  = 1'b1;
      rows_d = rows_img;
      bpr_d  = bpr_img;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 1'b0;
      rows_q <= '0;
      bpr_q  <= '0;
    end else if (shape_en) begin
      cfg_q  <= cfg_d;
      rows_q <= rows_d;
      bpr_q  <= bpr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      clear_q <= 1'b0;
    end else begin
      fault_q <= (act == ACT_FLT);
      clear_q <= (act == ACT_INIT);
    end
  end

  always_comb begin
    rb_image = '0;
    rb_image[PAL_OFS*8 +: 8] = {7'd0, cfg_q};
    for (int t = 0; t < NTILES; t++) begin
      rb_image[(ROWS_OFS + t)*8 +: ROW_W] = rows_q[t*ROW_W +: ROW_W];
      rb_image[(BPR_OFS + 2*t)*8 +: BPR_W] = bpr_q[t*BPR_W +: BPR_W];
    end
  end
endmodule

// File: rtl/tile_cfg_unit.sv
module tile_cfg_unit
  import tcfg_pkg::*;
#(
  parameter int NTILES     = 8,
  parameter int WORD_BYTES = 4,
  parameter int MAX_ROWS   = 16,
  parameter int MAX_BPR    = 64,
  parameter int BPR_ALIGN  = 4,
  localparam int WORD_BITS = WORD_BYTES * 8,
  localparam int WORDS     = IMG_BYTES / WORD_BYTES,
  localparam int AW        = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [WORD_BITS-1:0]    wr_data_i,
  input  logic                    commit_i,
  input  logic                    release_i,
  input  logic [AW-1:0]           rd_addr_i,
  output logic [WORD_BITS-1:0]    rd_data_o,
  output logic                    configured_o,
  output logic                    fault_o,
  output logic                    tile_clear_o,
  output logic [NTILES*ROW_W-1:0] tile_rows_o,
  output logic [NTILES*BPR_W-1:0] tile_bpr_o
);
  logic [IMG_BYTES*8-1:0] stage_img;
  logic [IMG_BYTES*8-1:0] rb_img;
  logic                   img_init;
  logic                   img_legal;

  tcfg_stage #(.WORD_BYTES(WORD_BYTES)) stage_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .image   (stage_img)
  );

  tcfg_validate #(
    .NTILES    (NTILES),
    .MAX_ROWS  (MAX_ROWS),
    .MAX_BPR   (MAX_BPR),
    .BPR_ALIGN (BPR_ALIGN)
  ) check_i (
    .image    (stage_img),
    .is_init  (img_init),
    .is_legal (img_legal)
  );

  tcfg_state #(.NTILES(NTILES)) state_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit_i),
    .release_req (release_i),
    .img_init    (img_init),
    .img_legal   (img_legal),
    .image       (stage_img),
    .cfg_q       (configured_o),
    .fault_q     (fault_o),
    .clear_q     (tile_clear_o),
    .rows_q      (tile_rows_o),
    .bpr_q       (tile_bpr_o),
    .rb_image    (rb_img)
  );

  always_comb begin
    rd_data_o = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (rd_addr_i == AW'(w)) rd_data_o = rb_img[w*WORD_BITS +: WORD_BITS];
    end
  end
endmodule

// File: rtl/tile_cfg_unit_chk.sv
module tile_cfg_unit_chk
  import tcfg_pkg::*;
#(
  parameter int NTILES    = 8,
  parameter int WORD_BITS = 32,
  parameter int MAX_ROWS  = 16,
  parameter int MAX_BPR   = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    commit_i,
  input logic                    release_i,
  input logic [WORD_BITS-1:0]    rd_data_o,
  input logic                    configured_o,
  input logic                    fault_o,
  input logic                    tile_clear_o,
  input logic [NTILES*ROW_W-1:0] tile_rows_o,
  input logic [NTILES*BPR_W-1:0] tile_bpr_o
);
  assert_fault_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(commit_i && !release_i));

  assert_fault_holds_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (configured_o == $past(configured_o)) &&
                (tile_rows_o == $past(tile_rows_o)) &&
                (tile_bpr_o == $past(tile_bpr_o)));

  assert_release_inits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(release_i) |-> (!configured_o && tile_clear_o));

  assert_release_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(release_i && commit_i) |-> !fault_o);

  assert_clear_is_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tile_clear_o |-> (!configured_o && !fault_o && tile_rows_o == '0 && tile_bpr_o == '0));

  assert_idle_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !configured_o |-> (rd_data_o == '0));

  for (genvar t = 0; t < NTILES; t++) begin : g_bound
    assert_shape_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tile_rows_o[t*ROW_W +: ROW_W] <= ROW_W'(MAX_ROWS)) &&
      (tile_bpr_o[t*BPR_W +: BPR_W] <= BPR_W'(MAX_BPR)));
  end
endmodule

bind tile_cfg_unit tile_cfg_unit_chk #(
  .NTILES    (NTILES),
  .WORD_BITS (WORD_BITS),
  .MAX_ROWS  (MAX_ROWS),
  .MAX_BPR   (MAX_BPR)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .commit_i     (commit_i),
  .release_i    (release_i),
  .rd_data_o    (rd_data_o),
  .configured_o (configured_o),
  .fault_o      (fault_o),
  .tile_clear_o (tile_clear_o),
  .tile_rows_o  (tile_rows_o),
  .tile_bpr_o   (tile_bpr_o)
);

// File: tb/tile_cfg_unit_tb_top.sv
module tile_cfg_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT  = 8;
  localparam int WB  = 4;
  localparam int NW  = 64 / WB;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [3:0]    wr_addr;
  logic [31:0]   wr_data;
  logic          commit;
  logic          rel;
  logic [3:0]    rd_addr;
  logic [31:0]   rd_data;
  logic          configured;
  logic          fault;
  logic          tclear;
  logic [63:0]   trows;
  logic [127:0]  tbpr;

  tile_cfg_unit dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en),
    .wr_addr_i    (wr_addr),
    .wr_data_i    (wr_data),
    .commit_i     (commit),
    .release_i    (rel),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .configured_o (configured),
    .fault_o      (fault),
    .tile_clear_o (tclear),
    .tile_rows_o  (trows),
    .tile_bpr_o   (tbpr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string phase  = "R9";

  // Reference model state
  byte unsigned stage_m [64];
  byte unsigned img     [64];
  bit           cfg_m;
  int           rows_m  [NT];
  int           bpr_m   [NT];
  bit           exp_fault;
  bit           exp_clear;

  task automatic chk(string tag, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s (phase %s): actual=%0h expected=%0h", tag, what, phase, got, exp);
    end
  endtask

  function automatic bit model_legal();
    if (stage_m[0] != 1) return 0;
    for (int b = 0; b < 64; b++) begin
      bit fld = (b == 0) || (b >= 16 && b < 16 + 2*NT) || (b >= 48 && b < 48 + NT);
      if (!fld && stage_m[b] != 0) return 0;
    end
    for (int t = 0; t < NT; t++) begin
      int r = stage_m[48+t];
      int w = stage_m[16+2*t] + 256 * stage_m[17+2*t];
      if (r > 16 || w > 64 || (w % 4) != 0) return 0;
    end
    return 1;
  endfunction

  function automatic logic [31:0] model_word(int a);
    logic [31:0] v = '0;
    for (int k = 0; k < WB; k++) begin
      int b = a*WB + k;
      int bv = 0;
      if (b == 0) bv = cfg_m;
      else if (b >= 16 && b < 16 + 2*NT) bv = ((b % 2) == 0) ? (bpr_m[(b-16)/2] % 256) : (bpr_m[(b-16)/2] / 256);
      else if (b >= 48 && b < 48 + NT) bv = rows_m[b-48];
      v[8*k +: 8] = 8'(bv);
    end
    return v;
  endfunction

  task automatic model_init();
    cfg_m = 0;
    for (int t = 0; t < NT; t++) begin rows_m[t] = 0; bpr_m[t] = 0; end
  endtask

  task automatic compare_all();
    chk("R3", "configured", 64'(configured), 64'(cfg_m));
    chk("R4", "fault", 64'(fault), 64'(exp_fault));
    chk("R5", "tile_clear", 64'(tclear), 64'(exp_clear));
    for (int t = 0; t < NT; t++) begin
      chk("R3", $sformatf("rows[%0d]", t), 64'(trows[t*8 +: 8]), 64'(rows_m[t]));
      chk("R3", $sformatf("bpr[%0d]", t), 64'(tbpr[t*16 +: 16]), 64'(bpr_m[t]));
    end
    chk("R7", $sformatf("rd_data[%0d]", rd_addr), 64'(rd_data), 64'(model_word(int'(rd_addr))));
  endtask

  task automatic tick();
    bit          we = wr_en;
    int          wa = int'(wr_addr);
    logic [31:0] wd = wr_data;
    bit          cm = commit;
    bit          rl = rel;
    @(posedge clk);
    exp_fault = 0;
    exp_clear = 0;
    if (rl) begin
      model_init(); exp_clear = 1;
    end else if (cm) begin
      if (stage_m[0] == 0) begin
        model_init(); exp_clear = 1;
      end else if (model_legal()) begin
        cfg_m = 1;
        for (int t = 0; t < NT; t++) begin
          rows_m[t] = stage_m[48+t];
          bpr_m[t]  = stage_m[16+2*t] + 256 * stage_m[17+2*t];
        end
      end else begin
        exp_fault = 1;
      end
    end
    if (we) for (int k = 0; k < WB; k++) stage_m[wa*WB + k] = wd[8*k +: 8];
    #1;
    compare_all();
    rd_addr = rd_addr + 4'd1;
  endtask

  task automatic write_img();
    for (int w = 0; w < NW; w++) begin
      wr_en = 1; wr_addr = 4'(w);
      for (int k = 0; k < WB; k++) wr_data[8*k +: 8] = img[w*WB + k];
      tick();
    end
    wr_en = 0;
  endtask

  task automatic do_commit();
    commit = 1; tick(); commit = 0; tick();
  endtask

  task automatic base_img(int seed);
    for (int b = 0; b < 64; b++) img[b] = 0;
    img[0] = 1;
    for (int t = 0; t < NT; t++) begin
      img[48+t] = byte'((t*3 + seed) % 17);
      img[16+2*t] = byte'(((t + seed) % 17) * 4);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog (R9): actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; commit = 0; rel = 0; rd_addr = 0;
    for (int b = 0; b < 64; b++) stage_m[b] = 0;
    model_init(); exp_fault = 0; exp_clear = 0;
    repeat (3) @(posedge clk);
    #1;
    phase = "R9";
    compare_all();
    rst_n = 1;
    tick();
    // R9: staging resets to zero, so a bare commit is an init commit
    do_commit();

    // R1 R2 R3: load a legal image word by word, then read it all back (R7)
    phase = "R1";
    base_img(1);
    write_img();
    chk("R1", "no effect before commit", 64'(configured), 64'd0);
    phase = "R3";
    do_commit();
    phase = "R7";
    for (int i = 0; i < NW; i++) tick();

    // R3 boundaries: 16 rows, 64-byte rows, and zero shapes
    phase = "R3";
    base_img(2);
    img[48] = 16; img[16] = 64; img[49] = 0; img[18] = 0;
    write_img();
    do_commit();

    // R4: each illegal kind, state must stay as loaded
    phase = "R4";
    base_img(3); img[0] = 2;          write_img(); do_commit();
    base_img(3); img[50] = 17;        write_img(); do_commit();
    base_img(3); img[20] = 68;        write_img(); do_commit();
    base_img(3); img[22] = 6;         write_img(); do_commit();
    base_img(3); img[5] = 8'h01;      write_img(); do_commit();
    base_img(3); img[63] = 8'h80;     write_img(); do_commit();
    base_img(3); img[25] = 8'h01;     write_img(); do_commit();
    chk("R4", "still configured after faults", 64'(configured), 64'd1);

    // R5: palette zero with junk elsewhere enters init without fault
    phase = "R5";
    base_img(4); img[0] = 0; img[7] = 8'hff; img[50] = 99;
    write_img();
    do_commit();

    // R6: release after a legal load
    phase = "R6";
    base_img(5); write_img(); do_commit();
    rel = 1; tick(); rel = 0; tick();

    // R8: release and commit of an illegal image together
    phase = "R8";
    base_img(6); write_img(); do_commit();
    base_img(6); img[0] = 7; write_img();
    commit = 1; rel = 1; tick(); commit = 0; rel = 0; tick();
    chk("R8", "no fault on collision", 64'(fault), 64'd0);

    // R10: staging write in the commit cycle only affects the next commit
    phase = "R10";
    base_img(7); write_img();
    wr_en = 1; wr_addr = 0; wr_data = 32'h0;
    commit = 1; tick(); commit = 0; wr_en = 0; tick();
    chk("R10", "image applied despite write", 64'(configured), 64'd1);
    do_commit();
    chk("R10", "later commit sees the write", 64'(configured), 64'd0);

    for (int i = 0; i < NW; i++) tick();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule